// File: doc/BRIEF.md
# Even/Odd Bank Bus Steering Unit

This block sits between a CPU-side load/store port and a memory built from two 8-bit banks. The even bank holds even byte addresses and drives the low data lanes. The odd bank holds odd byte addresses and drives the high lanes. The CPU presents one access at a time: a byte or a 16-bit word, read or write, at any byte address. The unit turns each access into one or two memory bus cycles. For every bus cycle it drives the word-select address lines, the bank-0 select line (address bit 0) and an active-low high-bank enable.

Aligned words and single bytes need one bus cycle. A word at an odd address needs two. The first cycle moves the low byte through the odd bank at the given address. The second cycle moves the high byte through the even bank at the next address. The unit puts each byte on the correct lane and rebuilds the 16-bit result for reads. Each bus cycle is held until the memory raises ready. The CPU sees a single-cycle completion pulse only after the final bus cycle has finished.

Top module: `dual_bank_steer`

## Requirements
- R1: A byte access at an even address makes one bus cycle with `mem_a0`=0 and `mem_bhe_n`=1, and `mem_addr_hi` equal to address bits [AW-1:1].
- R2: A byte access at an odd address makes one bus cycle with `mem_a0`=1 and `mem_bhe_n`=0, and `mem_addr_hi` equal to address bits [AW-1:1].
- R3: A word access at an even address makes exactly one bus cycle with `mem_a0`=0 and `mem_bhe_n`=0. Write data bits [7:0] go to lane [7:0], and read data is `mem_rdata` unchanged.
- R4: A word access at an odd address A makes exactly two bus cycles. The first has `mem_a0`=1, `mem_bhe_n`=0 and word address A[AW-1:1]. The second has `mem_a0`=0, `mem_bhe_n`=1 and word address A[AW-1:1]+1, which wraps to 0 at the top of the address space.
- R5: A byte read returns the selected bank's lane in `cpu_rdata[7:0]` with `cpu_rdata[15:8]`=0. For an odd address this is lane [15:8]; for an even address it is lane [7:0].
- R6: Every byte-wide bus cycle of a write carries the byte being written on both lanes. This covers byte writes and both halves of a split word write. In a split word write, the first cycle carries data bits [7:0] and the second carries data bits [15:8].
- R7: A split word read returns {lane [7:0] of the second cycle, lane [15:8] of the first cycle}.
- R8: `cpu_done` is high for exactly one cycle, in the cycle after the clock edge at which the final bus cycle saw `mem_ready`. From that cycle on, `cpu_rdata` stays unchanged until another request is accepted.
- R9: A request is accepted only when the unit is idle. Changes to `cpu_req` and the request fields while an access is in progress start no bus cycle and alter no bus field.
- R10: During a bus cycle, if `mem_ready` is low, then `mem_req`, address, enables and write data all hold their values into the next cycle.
- R11: After reset, `mem_req` and `cpu_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit word, 0 = byte |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 16 | Write data; bits [7:0] for bytes |
| cpu_rdata | output | 16 | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr_hi | output | AW-1 | Word select within each bank |
| mem_a0 | output | 1 | 0 enables the even bank |
| mem_bhe_n | output | 1 | 0 enables the odd bank |
| mem_wdata | output | 16 | Lane data toward memory |
| mem_rdata | input | 16 | Lane data from memory |
| mem_ready | input | 1 | Ends the current bus cycle |

## Verification
The hardest case to reach is a misaligned word whose second bus cycle crosses the top of the address space, while the memory inserts wait states and the CPU keeps changing its request fields mid-transfer. The bench drives this case directly: it issues an odd-address word at the last byte address with `cpu_req` held high and altered during the transfer. Around that directed case runs a long random mix of byte and word accesses with random wait states. Each result is compared against a byte-level reference memory, and every logged bus cycle is compared with the expected enables, address and lanes.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANE_W = 8;
  localparam int BUS_W  = 2 * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS1 = 2'd1,
    ST_BUS2 = 2'd2,
    ST_FIN  = 2'd3
  } dbs_state_e;
endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_word,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [BUS_W-1:0]  cpu_wdata,
  input  logic              mem_ready,
  output dbs_state_e        state_q,
  output logic              we_q,
  output logic              word_q,
  output logic [AW-1:0]     addr_q,
  output logic [BUS_W-1:0]  wdata_q,
  output logic              done
);
  dbs_state_e state_d;
  logic       accept;
  logic       split;

  assign accept = (state_q == ST_IDLE) && cpu_req;
  assign split  = word_q && addr_q[0];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept)    state_d = ST_BUS1;
      ST_BUS1: if (mem_ready) state_d = split ? ST_BUS2 : ST_FIN;
      ST_BUS2: if (mem_ready) state_d = ST_FIN;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= cpu_we;
      word_q  <= cpu_word;
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
  end

  assign done = (state_q == ST_FIN);

  a_r9_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(word_q) && $stable(we_q) && $stable(wdata_q)));

  a_r8_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_ready));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dbs_steer.sv
module dbs_steer
  import dbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dbs_state_e        state_q,
  input  logic              we_q,
  input  logic              word_q,
  input  logic [AW-1:0]     addr_q,
  input  logic [BUS_W-1:0]  wdata_q,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:1]     mem_addr_hi,
  output logic              mem_a0,
  output logic              mem_bhe_n,
  output logic [BUS_W-1:0]  mem_wdata
);
  logic              second;
  logic              aligned_word;
  logic [LANE_W-1:0] lane_byte;

  assign second       = (state_q == ST_BUS2);
  assign aligned_word = word_q && !addr_q[0];

  always_comb begin
    mem_req     = (state_q == ST_BUS1) || second;
    mem_we      = we_q && mem_req;
    mem_addr_hi = second ? addr_q[AW-1:1] + 1'b1 : addr_q[AW-1:1];
    mem_a0      = second ? 1'b0 : addr_q[0];
    mem_bhe_n   = second ? 1'b1 : (word_q ? 1'b0 : !addr_q[0]);
    lane_byte   = second ? wdata_q[BUS_W-1:LANE_W] : wdata_q[LANE_W-1:0];
    mem_wdata   = aligned_word ? wdata_q : {lane_byte, lane_byte};
  end

  a_r1_bank_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(mem_a0 && mem_bhe_n));

  a_r3_aligned_both: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && aligned_word) |-> (!mem_a0 && !mem_bhe_n));

  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr_hi) && $stable(mem_a0)
                                 && $stable(mem_bhe_n) && $stable(mem_wdata) && $stable(mem_we)));
endmodule

// File: rtl/dbs_rcap.sv
module dbs_rcap
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dbs_state_e        state_q,
  input  logic              we_q,
  input  logic              word_q,
  input  logic              a0_q,
  input  logic              mem_ready,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic [BUS_W-1:0]  cpu_rdata
);
  logic [BUS_W-1:0]  rdata_d;
  logic              cap_en;
  logic [LANE_W-1:0] lo_lane;
  logic [LANE_W-1:0] hi_lane;

  assign lo_lane = mem_rdata[LANE_W-1:0];
  assign hi_lane = mem_rdata[BUS_W-1:LANE_W];
  assign cap_en  = mem_ready && !we_q && ((state_q == ST_BUS1) || (state_q == ST_BUS2));

  always_comb begin
    rdata_d = cpu_rdata;
    if (state_q == ST_BUS2)   rdata_d = {lo_lane, cpu_rdata[LANE_W-1:0]};
    else if (!word_q)         rdata_d = {{LANE_W{1'b0}}, (a0_q ? hi_lane : lo_lane)};
    else if (a0_q)            rdata_d = {{LANE_W{1'b0}}, hi_lane};
    else                      rdata_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpu_rdata <= '0;
    else if (cap_en) cpu_rdata <= rdata_d;
  end

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |=> $stable(cpu_rdata));
endmodule

// File: rtl/dual_bank_steer.sv
module dual_bank_steer
  import dbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_word,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  output logic              cpu_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:1]     mem_addr_hi,
  output logic              mem_a0,
  output logic              mem_bhe_n,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready
);
  dbs_state_e       state_q;
  logic             we_q;
  logic             word_q;
  logic [AW-1:0]    addr_q;
  logic [BUS_W-1:0] wdata_q;

  dbs_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_ready(mem_ready), .state_q(state_q), .we_q(we_q), .word_q(word_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .done(cpu_done)
  );

  dbs_steer #(.AW(AW)) u_steer (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .we_q(we_q), .word_q(word_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .mem_ready(mem_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr_hi(mem_addr_hi), .mem_a0(mem_a0),
    .mem_bhe_n(mem_bhe_n), .mem_wdata(mem_wdata)
  );

  dbs_rcap u_rcap (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .we_q(we_q), .word_q(word_q),
    .a0_q(addr_q[0]), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .cpu_rdata(cpu_rdata)
  );

  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!mem_req && !cpu_done));
endmodule

// File: tb/tb_dual_bank_steer.sv
module tb_dual_bank_steer;
  localparam int AW = 20;

  logic          clk;
  logic          rst_n;
  logic          cpu_req, cpu_we, cpu_word;
  logic [AW-1:0] cpu_addr;
  logic [15:0]   cpu_wdata;
  logic [15:0]   cpu_rdata;
  logic          cpu_done;
  logic          mem_req, mem_we, mem_a0, mem_bhe_n;
  logic [AW-1:1] mem_addr_hi;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata;
  logic          mem_ready;

  dual_bank_steer #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr_hi(mem_addr_hi), .mem_a0(mem_a0),
    .mem_bhe_n(mem_bhe_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] refm [512];
  logic [7:0] even_m [256];
  logic [7:0] odd_m [256];

  logic          log_a0 [4];
  logic          log_bhe [4];
  logic [AW-1:1] log_hi [4];
  logic [15:0]   log_wd [4];
  logic          log_we [4];
  int            log_n;
  int            last_rdy;
  int            wcnt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: ready with random wait states, logs each completed bus cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      wcnt = 0;
    end else if (mem_req && !mem_ready) begin
      if (wcnt == 0) begin
        mem_rdata <= {odd_m[mem_addr_hi[8:1]], even_m[mem_addr_hi[8:1]]};
        if (mem_we) begin
          if (!mem_a0)    even_m[mem_addr_hi[8:1]] = mem_wdata[7:0];
          if (!mem_bhe_n) odd_m[mem_addr_hi[8:1]]  = mem_wdata[15:8];
        end
        if (log_n < 4) begin
          log_a0[log_n]  = mem_a0;
          log_bhe[log_n] = mem_bhe_n;
          log_hi[log_n]  = mem_addr_hi;
          log_wd[log_n]  = mem_wdata;
          log_we[log_n]  = mem_we;
        end
        log_n++;
        last_rdy = cyc;
        mem_ready <= 1'b1;
      end else begin
        wcnt--;
      end
    end else begin
      mem_ready <= 1'b0;
      wcnt = $urandom % 3;
    end
  end

  task automatic access(input bit we, input bit word, input logic [AW-1:0] a,
                        input logic [15:0] wd, input bit junk);
    int            n_exp;
    logic [AW-1:0] a1;
    logic [15:0]   exp_rd;
    logic [15:0]   got;
    int            guard;
    int            dcyc;
    a1 = a + 1'b1;
    n_exp = (word && a[0]) ? 2 : 1;
    exp_rd = word ? {refm[a1[8:0]], refm[a[8:0]]} : {8'h00, refm[a[8:0]]};
    @(negedge clk);
    log_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_word = word; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    if (junk) begin
      cpu_we = 1'b1; cpu_word = 1'b0; cpu_addr = a ^ 20'h00055; cpu_wdata = 16'hA5A5;
    end else begin
      cpu_req = 1'b0;
    end
    guard = 0;
    while (!cpu_done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    dcyc = cyc;
    got = cpu_rdata;
    cpu_req = 1'b0;
    chk(cpu_done, "R8 done seen", {31'd0, cpu_done}, 32'd1);
    chk(log_n == n_exp, "R9 bus cycle count", log_n, n_exp);
    chk(dcyc - last_rdy == 1, "R8 done one cycle after last ready", dcyc - last_rdy, 1);
    if (log_n == n_exp) begin
      if (word && !a[0]) begin
        chk({log_a0[0], log_bhe[0]} == 2'b00, "R3 aligned word enables", {log_a0[0], log_bhe[0]}, 2'b00);
        chk(log_hi[0] == a[AW-1:1], "R3 word address", log_hi[0], a[AW-1:1]);
        if (we) chk(log_wd[0] == wd, "R3 word lanes", log_wd[0], wd);
      end else if (word) begin
        chk({log_a0[0], log_bhe[0], log_a0[1], log_bhe[1]} == 4'b1001, "R4 split enables",
            {log_a0[0], log_bhe[0], log_a0[1], log_bhe[1]}, 4'b1001);
        chk(log_hi[0] == a[AW-1:1], "R4 first address", log_hi[0], a[AW-1:1]);
        chk(log_hi[1] == a1[AW-1:1], "R4 second address", log_hi[1], a1[AW-1:1]);
        if (we) begin
          chk(log_wd[0] == {wd[7:0], wd[7:0]}, "R6 split low byte lanes", log_wd[0], {wd[7:0], wd[7:0]});
          chk(log_wd[1] == {wd[15:8], wd[15:8]}, "R6 split high byte lanes", log_wd[1], {wd[15:8], wd[15:8]});
        end
      end else if (!a[0]) begin
        chk({log_a0[0], log_bhe[0]} == 2'b01, "R1 even byte enables", {log_a0[0], log_bhe[0]}, 2'b01);
        chk(log_hi[0] == a[AW-1:1], "R1 byte address", log_hi[0], a[AW-1:1]);
      end else begin
        chk({log_a0[0], log_bhe[0]} == 2'b10, "R2 odd byte enables", {log_a0[0], log_bhe[0]}, 2'b10);
        chk(log_hi[0] == a[AW-1:1], "R2 byte address", log_hi[0], a[AW-1:1]);
      end
      if (we && !word)
        chk(log_wd[0] == {wd[7:0], wd[7:0]}, "R6 byte write lanes", log_wd[0], {wd[7:0], wd[7:0]});
      for (int i = 0; i < n_exp; i++)
        chk(log_we[i] == we, "R9 bus direction unchanged", log_we[i], we);
    end
    if (!we) chk(got == exp_rd, word ? (a[0] ? "R7 split read data" : "R3 word read data")
                                     : "R5 byte read data", got, exp_rd);
    if (we) begin
      refm[a[8:0]] = wd[7:0];
      if (word) refm[a1[8:0]] = wd[15:8];
    end
    @(negedge clk);
    chk(!cpu_done, "R8 done single cycle", {31'd0, cpu_done}, 32'd0);
    chk(cpu_rdata == got, "R8 read data held", cpu_rdata, got);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 512; i++) refm[i] = 8'(i * 7 + 3);
    for (int j = 0; j < 256; j++) begin
      even_m[j] = refm[2*j];
      odd_m[j]  = refm[2*j+1];
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_word = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; mem_rdata = '0; mem_ready = 1'b0; log_n = 0; last_rdy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req, "R11 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(!cpu_done, "R11 cpu_done after reset", {31'd0, cpu_done}, 32'd0);

    access(1'b0, 1'b0, 20'h00010, 16'h0, 1'b0);          // R1 even byte read
    access(1'b0, 1'b0, 20'h00011, 16'h0, 1'b0);          // R2 / R5 odd byte read
    access(1'b1, 1'b0, 20'h00021, 16'h003C, 1'b0);       // R6 odd byte write
    access(1'b0, 1'b1, 20'h00020, 16'h0, 1'b0);          // R3 word read sees the byte
    access(1'b1, 1'b1, 20'h00033, 16'hBEEF, 1'b0);       // R4 / R6 split write
    access(1'b0, 1'b1, 20'h00033, 16'h0, 1'b0);          // R7 split read
    access(1'b0, 1'b1, 20'hFFFFF, 16'h0, 1'b1);          // R4 wrap with R9 junk held
    access(1'b1, 1'b1, 20'hFFFFF, 16'h1234, 1'b1);       // R9 during split write
    access(1'b0, 1'b1, 20'h00000, 16'h0, 1'b0);          // wrap target reread
    for (int k = 0; k < 400; k++)
      access(1'($urandom), 1'($urandom), AW'($urandom), 16'($urandom), (k % 9) == 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule